// File: doc/BRIEF.md
# Wake-Up Sleep Event Timer

This block keeps time during low-power intervals. It counts the rising edges of a slow reference clock in a 31-bit counter and tells the rest of the chip when a programmed interval has passed. A 2-bit resolution code picks one of four 16-bit windows of that counter. The chosen window is the value that can be read and the value that is compared with a 16-bit event value. Each step of the resolution code moves the window up by five bits, so one unit of the event value stands for 1, 32, 1024 or 32768 slow-clock periods.

When the window reaches the event value, the counter starts again from zero. The block then gives a one-cycle wake pulse and sets a sticky event flag. It also sets a CPU-level interrupt flag, but only if the event is unmasked. Software writes the settings through a byte-wide write port. The event value is staged when it is written and becomes active only on a slow-clock edge. A reset strobe loads the counter with 4 and holds it there for two slow edges. The slow clock passes through a two-flop synchroniser and drives a tick in the fast clock domain, so all the logic runs on one system clock with a synchronous active-high reset.

Top module: `wut_sleep_timer`

## Requirements
- R1: After reset, `wake_o`, `evt_flag_o` and `irq_o` are 0 and the read window `{time_hi_o,time_lo_o}` is 0. The event mask is 0 and the resolution code is 00.
- R2: The counter advances by exactly one for each rising edge of `slow_clk_i`. With resolution code 00 the read window is counter bits 15:0, with `time_lo_o` carrying window bits 7:0 and `time_hi_o` carrying bits 15:8.
- R3: Control register address 2, bits 1:0, is the resolution code. Code 01 shows counter bits 20:5, code 10 shows bits 25:10 and code 11 shows bits 30:15.
- R4: Writing a new resolution code changes only which window is shown. It does not change the counter itself.
- R5: Writing address 2 with bit 2 set loads the counter with 4. The counter then stays at 4, with no event compare, through the next two rising slow edges, and advances again on the third.
- R6: On a rising slow edge where the selected window of the incremented counter equals the active event value, the counter restarts at 0 and `wake_o` pulses for one clock. Events therefore repeat every EVENT × 2^(5·code) slow periods.
- R7: An event sets `evt_flag_o`, and the flag stays set. A write to address 3 with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 leaves it unchanged.
- R8: An event sets `irq_o` only when the mask (address 3, bit 4) is 1. A write to address 3 with bit 1 equal to 0 clears `irq_o`.
- R9: The event value bytes are written separately, the low byte at address 0 and the high byte at address 1, into a staging register. The active value is copied from staging only on a rising slow edge. The compare at that edge still uses the earlier active value.
- R10: An event value below the current window value causes no event until the counter wraps or is reset by the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 event low, 1 event high, 2 control, 3 interrupt |
| wr_data_i | input | 8 | Write data |
| wake_o | output | 1 | One-clock pulse on each event |
| evt_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Masked CPU-level interrupt flag |
| time_lo_o | output | 8 | Low byte of the selected counter window |
| time_hi_o | output | 8 | High byte of the selected counter window |

## Verification
If the counter is wrong, the read window shows it within a few clocks of the next slow edge. If the window-select logic is wrong, the window shown is wrong as soon as the resolution code changes. If the active event value or the hold count is wrong, the error only appears at the end of a period, as a wake pulse that is early, late or missing. The long-resolution runs compare the total number of events on the cycle just before an expected event and again just after it, which exposes an off-by-one period at once. Flag and mask faults show on `evt_flag_o` and `irq_o` one clock after the wake pulse, or right after the clearing write.

// File: rtl/wut_pkg.sv
package wut_pkg;
  typedef enum logic [1:0] {
    REG_EVT_LO = 2'd0,
    REG_EVT_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_IRQ    = 2'd3
  } reg_addr_e;

  localparam int CTRL_STROBE_BIT = 2;
  localparam int IRQ_EVT_BIT     = 0;
  localparam int IRQ_CPU_BIT     = 1;
  localparam int IRQ_MASK_BIT    = 4;
endpackage

// File: rtl/wut_tick_sync.sv
module wut_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic tick_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      tick_o <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-1:0], async_i};
      tick_o <= sh_q[STAGES-1] & ~sh_q[STAGES];
    end
  end
endmodule

// File: rtl/wut_win_sel.sv
module wut_win_sel #(
  parameter int CNT_W = 31,
  parameter int WIN_W = 16,
  parameter int STEP  = 5,
  parameter int RES_W = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [RES_W-1:0] res_i,
  output logic [WIN_W-1:0] win_o
);
  localparam int NRES = 1 << RES_W;

  logic [WIN_W-1:0] win_a [NRES];

  for (genvar g = 0; g < NRES; g++) begin : g_win
    assign win_a[g] = cnt_i[g*STEP +: WIN_W];
  end

  assign win_o = win_a[res_i];
endmodule

// File: rtl/wut_regs.sv
module wut_regs
  import wut_pkg::*;
#(
  parameter int          RES_W   = 2,
  parameter int          EVT_W   = 16,
  parameter logic [15:0] EVT_RST = 16'h876B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [EVT_W-1:0] stage_o,
  output logic [RES_W-1:0] res_o,
  output logic             mask_o,
  output logic             strobe_o,
  output logic             clr_evt_o,
  output logic             clr_cpu_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_o   <= EVT_RST[EVT_W-1:0];
      res_o     <= '0;
      mask_o    <= 1'b0;
      strobe_o  <= 1'b0;
      clr_evt_o <= 1'b0;
      clr_cpu_o <= 1'b0;
    end else begin
      strobe_o  <= 1'b0;
      clr_evt_o <= 1'b0;
      clr_cpu_o <= 1'b0;
      if (wr_en_i) begin
        case (wr_addr_i)
          REG_EVT_LO: stage_o[7:0]       <= wr_data_i;
          REG_EVT_HI: stage_o[EVT_W-1:8] <= wr_data_i[EVT_W-9:0];
          REG_CTRL: begin
            res_o    <= wr_data_i[RES_W-1:0];
            strobe_o <= wr_data_i[CTRL_STROBE_BIT];
          end
          default: begin
            mask_o    <= wr_data_i[IRQ_MASK_BIT];
            clr_evt_o <= ~wr_data_i[IRQ_EVT_BIT];
            clr_cpu_o <= ~wr_data_i[IRQ_CPU_BIT];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/wut_core.sv
module wut_core #(
  parameter int          CNT_W      = 31,
  parameter int          WIN_W      = 16,
  parameter int          STEP       = 5,
  parameter int          RES_W      = 2,
  parameter int          PRELOAD    = 4,
  parameter int          HOLD_TICKS = 2,
  parameter logic [15:0] EVT_RST    = 16'h876B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             strobe_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [WIN_W-1:0] stage_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [CNT_W-1:0]  nxt;
  logic [WIN_W-1:0]  nxt_win;
  logic [WIN_W-1:0]  act_q;
  logic [HOLD_W-1:0] hold_q;
  logic              match;

  assign nxt = cnt_o + 1'b1;

  wut_win_sel #(.CNT_W(CNT_W), .WIN_W(WIN_W), .STEP(STEP), .RES_W(RES_W)) u_nxt_sel (
    .cnt_i(nxt),
    .res_i(res_i),
    .win_o(nxt_win)
  );

  assign match = (nxt_win == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      act_q  <= EVT_RST[WIN_W-1:0];
      hold_q <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (tick_i) act_q <= stage_i;
      if (strobe_i) begin
        cnt_o  <= CNT_W'(PRELOAD);
        hold_q <= HOLD_W'(HOLD_TICKS);
      end else if (tick_i) begin
        if (hold_q != '0) begin
          hold_q <= hold_q - 1'b1;
        end else if (match) begin
          cnt_o  <= '0;
          fire_o <= 1'b1;
        end else begin
          cnt_o <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/wut_flags.sv
module wut_flags (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic mask_i,
  input  logic clr_evt_i,
  input  logic clr_cpu_i,
  output logic evt_flag_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (fire_i)         evt_flag_o <= 1'b1;
      else if (clr_evt_i) evt_flag_o <= 1'b0;
      if (fire_i && mask_i) irq_o <= 1'b1;
      else if (clr_cpu_i)   irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wut_sleep_timer.sv
module wut_sleep_timer #(
  parameter int          CNT_W       = 31,
  parameter int          WIN_W       = 16,
  parameter int          STEP        = 5,
  parameter int          RES_W       = 2,
  parameter int          PRELOAD     = 4,
  parameter int          HOLD_TICKS  = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] EVT_RST     = 16'h876B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_clk_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       wake_o,
  output logic       evt_flag_o,
  output logic       irq_o,
  output logic [7:0] time_lo_o,
  output logic [7:0] time_hi_o
);
  localparam int BYTE_W = 8;

  logic             tick_w, strobe_w, mask_w, clr_evt_w, clr_cpu_w, fire_w;
  logic [RES_W-1:0] res_w;
  logic [WIN_W-1:0] stage_w, win_w, win_q;
  logic [CNT_W-1:0] cnt_w;

  wut_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(slow_clk_i), .tick_o(tick_w)
  );

  wut_regs #(.RES_W(RES_W), .EVT_W(WIN_W), .EVT_RST(EVT_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .stage_o(stage_w), .res_o(res_w), .mask_o(mask_w),
    .strobe_o(strobe_w), .clr_evt_o(clr_evt_w), .clr_cpu_o(clr_cpu_w)
  );

  wut_core #(
    .CNT_W(CNT_W), .WIN_W(WIN_W), .STEP(STEP), .RES_W(RES_W),
    .PRELOAD(PRELOAD), .HOLD_TICKS(HOLD_TICKS), .EVT_RST(EVT_RST)
  ) u_core (
    .clk(clk), .rst(rst), .tick_i(tick_w), .strobe_i(strobe_w),
    .res_i(res_w), .stage_i(stage_w), .cnt_o(cnt_w), .fire_o(fire_w)
  );

  wut_flags u_flags (
    .clk(clk), .rst(rst), .fire_i(fire_w), .mask_i(mask_w),
    .clr_evt_i(clr_evt_w), .clr_cpu_i(clr_cpu_w),
    .evt_flag_o(evt_flag_o), .irq_o(irq_o)
  );

  wut_win_sel #(.CNT_W(CNT_W), .WIN_W(WIN_W), .STEP(STEP), .RES_W(RES_W)) u_rd_sel (
    .cnt_i(cnt_w), .res_i(res_w), .win_o(win_w)
  );

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_w;
  end

  assign wake_o    = fire_w;
  assign time_lo_o = win_q[BYTE_W-1:0];
  assign time_hi_o = win_q[WIN_W-1:BYTE_W];
endmodule

// File: rtl/wut_sleep_timer_chk.sv
module wut_sleep_timer_chk #(
  parameter int CNT_W   = 31,
  parameter int PRELOAD = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             strobe,
  input logic             mask,
  input logic [CNT_W-1:0] cnt,
  input logic             wake,
  input logic             evt_flag,
  input logic             irq
);
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !strobe) |=> $stable(cnt)); // R2

  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (cnt == CNT_W'(PRELOAD))); // R5

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake); // R6

  AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (rst)
    wake |-> (cnt == '0)); // R6

  AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
    wake |=> evt_flag); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mask)); // R8
endmodule

bind wut_sleep_timer wut_sleep_timer_chk #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .strobe(strobe_w), .mask(mask_w),
  .cnt(cnt_w), .wake(wake_o), .evt_flag(evt_flag_o), .irq(irq_o)
);

// File: tb/wut_sleep_timer_tb.sv
module wut_sleep_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wake, ef, cf;
  logic [7:0] tlo, thi;

  always #5 clk = ~clk;

  wut_sleep_timer dut_i (
    .clk(clk), .rst(rst), .slow_clk_i(slow), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wake_o(wake),
    .evt_flag_o(ef), .irq_o(cf), .time_lo_o(tlo), .time_hi_o(thi)
  );

  typedef struct {
    logic [15:0] win;
    int          wakes;
    bit          ef;
    bit          cf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_err = 0;
  int    wake_cnt = 0;
  bit    done = 0;
  event  smp_ev;

  // reference model
  logic [30:0] m_cnt = '0;
  int          m_hold = 0;
  logic [15:0] m_act = 16'h876B;
  logic [15:0] m_stage = 16'h876B;
  int          m_res = 0;
  bit          m_ef = 0, m_cf = 0, m_mask = 0;
  int          m_wakes = 0;

  function automatic logic [15:0] win_of(input logic [30:0] c, input int r);
    logic [30:0] s;
    s = c >> (5 * r);
    return s[15:0];
  endfunction

  always @(posedge clk) if (!rst && wake) wake_cnt++;

  task automatic model_tick();
    logic [15:0] old_act;
    logic [30:0] nx;
    old_act = m_act;
    m_act   = m_stage;
    if (m_hold > 0) m_hold--;
    else begin
      nx = m_cnt + 31'd1;
      if (win_of(nx, m_res) == old_act) begin
        m_cnt = '0;
        m_ef  = 1;
        if (m_mask) m_cf = 1;
        m_wakes++;
      end else m_cnt = nx;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_stage[7:0]  = d;
      2'd1: m_stage[15:8] = d;
      2'd2: begin
        m_res = int'(d[1:0]);
        if (d[2]) begin m_cnt = 31'd4; m_hold = 2; end
      end
      default: begin
        m_mask = d[4];
        if (!d[0]) m_ef = 0;
        if (!d[1]) m_cf = 0;
      end
    endcase
    repeat (3) @(negedge clk);
  endtask

  task automatic slow_step(input int h);
    slow = 1'b1;
    model_tick();
    repeat (h) @(negedge clk);
    slow = 1'b0;
    repeat (h) @(negedge clk);
  endtask

  task automatic fast_run(input int n);
    for (int i = 0; i < n; i++) slow_step(2);
    repeat (6) @(negedge clk);
  endtask

  task automatic check(input string tag);
    exp_t e;
    e.win = win_of(m_cnt, m_res); e.wakes = m_wakes; e.ef = m_ef; e.cf = m_cf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ->smp_ev;
    #1;
  endtask

  task automatic step_check(input string tag);
    slow_step(6);
    check(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if ({thi, tlo} !== e.win || wake_cnt != e.wakes || ef !== e.ef || cf !== e.cf) begin
          n_err++;
          $display("FAIL %s: win=%h wakes=%0d ef=%b irq=%b expected win=%h wakes=%0d ef=%b irq=%b",
                   t, {thi, tlo}, wake_cnt, ef, cf, e.win, e.wakes, e.ef, e.cf);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset state");

    // R9: bytes written separately, active event value zero
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) step_check("R2 one count per slow edge");

    // R3 / R4: window selection over a larger count
    fast_run(1100);
    check("R2 count after fast run");
    wr(2'd2, 8'h01); check("R3 code 01 window bits 20:5");
    wr(2'd2, 8'h02); check("R3 code 10 window bits 25:10");
    wr(2'd2, 8'h03); check("R3 code 11 window bits 30:15");
    wr(2'd2, 8'h00); check("R4 counter kept across resolution change");

    // R5: strobe preload and hold
    wr(2'd2, 8'h04); check("R5 preload to 4");
    step_check("R5 held at first edge");
    step_check("R5 held at second edge");
    step_check("R5 advances on third edge");

    // R6 / R7: periodic event, mask off
    wr(2'd0, 8'h08);
    for (int i = 0; i < 18; i++) step_check("R6 periodic event res 00");

    wr(2'd3, 8'h03); check("R7 flag kept by write of 1");
    wr(2'd3, 8'h02); check("R7 flag cleared by write of 0");

    // R8: mask on
    wr(2'd3, 8'h13);
    for (int i = 0; i < 8; i++) step_check("R8 irq set with mask");
    wr(2'd3, 8'h11); check("R8 irq cleared, event flag kept");
    wr(2'd3, 8'h10); check("R7 both flags cleared");

    // R6: code 01, event 3 -> period 96
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h03);
    fast_run(285); check("R6 code 01 before third event");
    step_check("R6 code 01 third event");

    // R6: code 10, event 1 -> period 1024
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h01);
    fast_run(2045); check("R6 code 10 before second event");
    step_check("R6 code 10 second event");

    // R9: staged value takes effect only on a slow edge
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h0A);
    step_check("R9 hold edge one");
    step_check("R9 hold edge two");
    step_check("R9 count to 5");
    wr(2'd0, 8'h06);
    for (int i = 0; i < 6; i++) step_check("R9 old value used at edge, no event");

    // R10: event below current window
    wr(2'd0, 8'h02);
    for (int i = 0; i < 20; i++) slow_step(6);
    check("R10 no event below window");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule